// File: doc/BRIEF.md
# SPI Master Frame Engine with Per-Command Attribute Sets

The block is an SPI master that pulls command entries from an external transmit queue and runs one SPI frame for each. Every entry carries a data word, a one-bit set selector and a clear-counter flag. The selector picks one of two stored attribute sets. Each set holds the frame length, clock polarity, clock phase, bit order, baud divider and three chip-select timing delays. The engine drives the serial clock, MOSI and an active-low chip select, samples MISO, and pushes the received word into an external receive queue.

A 16-bit counter of completed frames runs beside the engine. Software can preset it, and any command can clear it at frame start. Software programs the two attribute sets and the counter through a single write port. A write to an attribute set while a frame is in flight is dropped.

Register write addresses: 0 selects attribute set 0, 1 selects set 1, and 2 selects the counter (low 16 bits of the write data). The attribute word has these fields:
- bits [3:0]: frame size, where the length is the field plus one.
- bit 4: clock polarity.
- bit 5: clock phase.
- bit 6: LSB first.
- bits [10:7]: baud divider.
- bits [14:11]: chip-select-to-clock delay.
- bits [18:15]: after-clock delay.
- bits [22:19]: inter-frame gap.

Top module: `spi_attr_master`

## Requirements
- R1: After reset, cs_n is 1, sclk, mosi, tx_pop and rx_push are 0, xfer_cnt is 0, and both attribute sets have frame size 15 (16-bit frames) with every other field at zero.
- R2: A frame starts, with one tx_pop pulse, only when tx_empty is 0 and rx_full is 0. While rx_full is 1, no entry is popped and cs_n stays high.
- R3: tx_sel=0 makes the frame use attribute set 0, and tx_sel=1 makes it use set 1. The choice is made entry by entry.
- R4: A frame has (frame size field + 1) bits, which gives 2×(field+1) serial clock transitions.
- R5: With LSB first = 0, the word goes out on mosi from bit (length−1) down to bit 0. With LSB first = 1, it goes out from bit 0 upward.
- R6: sclk rests at the polarity bit while no frame is running. With phase 0, each bit is on mosi before the leading edge and MISO is sampled on that edge. With phase 1, mosi changes on the leading edge and MISO is sampled on the trailing edge.
- R7: Consecutive sclk transitions within a frame are (baud+1) system clocks apart.
- R8: The first sclk transition comes (cs delay+1)+(baud+1) clocks after cs_n falls. cs_n rises (after-clock delay+1) clocks after the last transition. Between back-to-back frames, cs_n stays high for (gap+2) clocks.
- R9: When cs_n rises, rx_push pulses once and rx_data holds the sampled bits placed by the same bit order, with zeros above the frame length.
- R10: xfer_cnt goes up by one when the last bit of a frame completes, and it wraps from 0xFFFF to 0.
- R11: A frame whose entry has tx_clr=1 sets xfer_cnt to 0 at frame start, so the count is 1 once that frame ends.
- R12: A counter write loads xfer_cnt with the written value on the next clock.
- R13: An attribute-set write that arrives while a frame is running is dropped, and the stored set keeps its old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 set 0, 1 set 1, 2 counter |
| reg_wdata | input | 23 | Register write data |
| tx_empty | input | 1 | Transmit queue has no entry |
| tx_sel | input | 1 | Head entry: attribute set selector |
| tx_clr | input | 1 | Head entry: clear counter at frame start |
| tx_data | input | 16 | Head entry: data word to send |
| tx_pop | output | 1 | Removes the head entry of the transmit queue |
| rx_full | input | 1 | Receive queue has no space |
| rx_push | output | 1 | Writes rx_data into the receive queue |
| rx_data | output | 16 | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| xfer_cnt | output | 16 | Completed-frame counter |

## Verification
The bench acts as a slave that decodes mosi on the edge the phase bit names and drives its own pattern on miso. Because of this, a swapped phase, polarity or bit order changes the captured word or the received word, not only the clock shape. Directed frames cover the reset-default 16-bit frame, two hand-picked sets used alternately back to back, a held receive-full condition, counter preset, wrap and per-command clear, and an attribute write made mid-frame. Seeded random batches then re-program both sets with random lengths, modes, dividers and delays and send random words with random selectors. Each frame is checked for bit count, spacing of transitions, chip-select margins, idle clock level and counter value.

// File: rtl/spi_attr_pkg.sv
package spi_attr_pkg;
  parameter int DW     = 16;
  parameter int FSZ_W  = $clog2(DW);
  parameter int BAUD_W = 4;
  parameter int DLY_W  = 4;
  parameter int CNT_W  = 16;
  parameter int N_SETS = 2;
  parameter int SEL_W  = $clog2(N_SETS);
  parameter int REG_AW = $clog2(N_SETS + 1);
  parameter int ATTR_W = FSZ_W + 3 + BAUD_W + 3 * DLY_W;

  typedef struct packed {
    logic [DLY_W-1:0]  dt;
    logic [DLY_W-1:0]  asc;
    logic [DLY_W-1:0]  cssck;
    logic [BAUD_W-1:0] baud;
    logic              lsbf;
    logic              cpha;
    logic              cpol;
    logic [FSZ_W-1:0]  fsz;
  } attr_t;

  localparam attr_t ATTR_RST = '{dt: '0, asc: '0, cssck: '0, baud: '0,
                                 lsbf: 1'b0, cpha: 1'b0, cpol: 1'b0, fsz: '1};

  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL, ST_GAP} eng_st_t;

  // position in the data word of the j-th bit on the wire
  function automatic logic [FSZ_W-1:0] bit_pos(attr_t a, logic [FSZ_W-1:0] j);
    return a.lsbf ? j : a.fsz - j;
  endfunction
endpackage

// File: rtl/spi_attr_bank.sv
module spi_attr_bank
  import spi_attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             lock,
  input  logic [SEL_W-1:0] wr_idx,
  input  attr_t            wr_data,
  output attr_t            sets [N_SETS]
);
  for (genvar g = 0; g < N_SETS; g++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst)
        sets[g] <= ATTR_RST;
      else if (wr_en && !lock && wr_idx == SEL_W'(g))
        sets[g] <= wr_data;
    end
  end
endmodule

// File: rtl/spi_xfer_counter.sv
module spi_xfer_counter
  import spi_attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             preset_en,
  input  logic [CNT_W-1:0] preset_val,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (preset_en) cnt <= preset_val;
    else if (clr)       cnt <= inc ? CNT_W'(1) : '0;
    else if (inc)       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_attr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_empty,
  input  logic          rx_full,
  input  logic          tx_clr,
  input  logic [DW-1:0] tx_data,
  input  attr_t         attr_in,
  input  logic          miso,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [DW-1:0] rx_data,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_n,
  output logic          busy,
  output logic          clr_pulse,
  output logic          last_bit
);
  localparam int EW = FSZ_W + 1;

  eng_st_t           st;
  attr_t             at;
  logic [DW-1:0]     txw, rxw;
  logic [FSZ_W-1:0]  k;
  logic [EW-1:0]     e;
  logic [BAUD_W-1:0] hc;
  logic [DLY_W-1:0]  dc;

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; at <= ATTR_RST; txw <= '0; rxw <= '0;
      k <= '0; e <= '0; hc <= '0; dc <= '0;
      tx_pop <= 1'b0; rx_push <= 1'b0; rx_data <= '0;
      sclk <= 1'b0; mosi <= 1'b0; cs_n <= 1'b1;
      clr_pulse <= 1'b0; last_bit <= 1'b0;
    end else begin
      tx_pop <= 1'b0; rx_push <= 1'b0; clr_pulse <= 1'b0; last_bit <= 1'b0;
      case (st)
        ST_IDLE: if (!tx_empty && !rx_full) begin
          tx_pop <= 1'b1; clr_pulse <= tx_clr;
          at <= attr_in; txw <= tx_data; rxw <= '0;
          k <= '0; e <= '0; hc <= '0; dc <= attr_in.cssck;
          cs_n <= 1'b0; sclk <= attr_in.cpol;
          mosi <= attr_in.cpha ? 1'b0 : tx_data[bit_pos(attr_in, '0)];
          st <= ST_LEAD;
        end
        ST_LEAD: if (dc == '0) st <= ST_SHIFT; else dc <= dc - 1'b1;
        ST_SHIFT: if (hc == at.baud) begin
          hc <= '0; sclk <= ~sclk; e <= e + 1'b1;
          if (!e[0]) begin                       // leading edge
            if (!at.cpha) rxw[bit_pos(at, k)] <= miso;
            else          mosi <= txw[bit_pos(at, k)];
          end else begin                         // trailing edge
            if (!at.cpha) begin
              if (k != at.fsz) mosi <= txw[bit_pos(at, k + 1'b1)];
            end else rxw[bit_pos(at, k)] <= miso;
            k <= k + 1'b1;
          end
          if (e == {at.fsz, 1'b1}) begin
            last_bit <= 1'b1; dc <= at.asc; st <= ST_TRAIL;
          end
        end else hc <= hc + 1'b1;
        ST_TRAIL: if (dc == '0) begin
          cs_n <= 1'b1; rx_push <= 1'b1; rx_data <= rxw;
          dc <= at.dt; st <= ST_GAP;
        end else dc <= dc - 1'b1;
        ST_GAP: if (dc == '0) st <= ST_IDLE; else dc <= dc - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_attr_master.sv
module spi_attr_master
  import spi_attr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ATTR_W-1:0] reg_wdata,
  input  logic              tx_empty,
  input  logic [SEL_W-1:0]  tx_sel,
  input  logic              tx_clr,
  input  logic [DW-1:0]     tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [DW-1:0]     rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n,
  output logic [CNT_W-1:0]  xfer_cnt
);
  attr_t                    sets [N_SETS];
  attr_t [N_SETS-1:0]       sets_flat;
  logic                     attr_wr, cnt_wr, eng_busy, cnt_clr, cnt_inc;

  assign attr_wr = reg_wr && (reg_addr < REG_AW'(N_SETS));
  assign cnt_wr  = reg_wr && (reg_addr == REG_AW'(N_SETS));

  for (genvar g = 0; g < N_SETS; g++) begin : g_flat
    assign sets_flat[g] = sets[g];
  end

  spi_attr_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(attr_wr), .lock(eng_busy),
    .wr_idx(reg_addr[SEL_W-1:0]), .wr_data(attr_t'(reg_wdata)), .sets(sets)
  );

  spi_frame_engine u_eng (
    .clk(clk), .rst(rst), .tx_empty(tx_empty), .rx_full(rx_full),
    .tx_clr(tx_clr), .tx_data(tx_data), .attr_in(sets[tx_sel]), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(eng_busy),
    .clr_pulse(cnt_clr), .last_bit(cnt_inc)
  );

  spi_xfer_counter u_cnt (
    .clk(clk), .rst(rst), .preset_en(cnt_wr),
    .preset_val(reg_wdata[CNT_W-1:0]), .clr(cnt_clr), .inc(cnt_inc),
    .cnt(xfer_cnt)
  );
endmodule

// File: rtl/spi_attr_master_chk.sv
module spi_attr_master_chk
  import spi_attr_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               tx_empty,
  input logic               rx_full,
  input logic               tx_pop,
  input logic               rx_push,
  input logic               cs_n,
  input logic               sclk,
  input logic               reg_wr,
  input logic [ATTR_W-1:0]  reg_wdata,
  input logic [CNT_W-1:0]   xfer_cnt,
  input logic               cnt_inc,
  input logic               cnt_clr,
  input logic               cnt_wr,
  input logic               eng_busy,
  input attr_t [N_SETS-1:0] sets_flat
);
  a_r2_pop_gated: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> $past(!tx_empty && !rx_full));

  a_r6_idle_clock: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |-> $stable(sclk));

  a_r9_push_at_cs_rise: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> $rose(cs_n));

  a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_inc && !cnt_clr && !cnt_wr) |=> xfer_cnt == $past(xfer_cnt) + 1'b1);

  a_r11_clear_at_start: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr && !cnt_wr) |=> xfer_cnt == '0);

  a_r12_preset: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> xfer_cnt == $past(reg_wdata[CNT_W-1:0]));

  a_r13_locked_sets: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && eng_busy) |=> $stable(sets_flat));
endmodule

bind spi_attr_master spi_attr_master_chk chk_i (
  .clk(clk), .rst(rst), .tx_empty(tx_empty), .rx_full(rx_full),
  .tx_pop(tx_pop), .rx_push(rx_push), .cs_n(cs_n), .sclk(sclk),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .xfer_cnt(xfer_cnt),
  .cnt_inc(cnt_inc), .cnt_clr(cnt_clr), .cnt_wr(cnt_wr),
  .eng_busy(eng_busy), .sets_flat(sets_flat)
);

// File: tb/spi_attr_master_tb_top.sv
module spi_attr_master_tb_top;
  import spi_attr_pkg::*;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic              reg_wr = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [ATTR_W-1:0] reg_wdata = '0;
  logic              tx_empty, tx_clr, tx_pop, rx_full = 1'b0, rx_push;
  logic [SEL_W-1:0]  tx_sel;
  logic [DW-1:0]     tx_data, rx_data;
  logic              sclk, mosi, miso = 1'b0, cs_n;
  logic [CNT_W-1:0]  xfer_cnt;

  logic [SEL_W-1:0] q_sel [64];
  logic             q_clr [64];
  logic [DW-1:0]    q_data [64];
  logic [DW-1:0]    q_pat [64];
  int qh = 0, qt = 0;

  assign tx_empty = (qh == qt);
  assign tx_sel   = q_sel[qh % 64];
  assign tx_clr   = q_clr[qh % 64];
  assign tx_data  = q_data[qh % 64];

  spi_attr_master dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .tx_empty(tx_empty), .tx_sel(tx_sel), .tx_clr(tx_clr), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .xfer_cnt(xfer_cnt)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pos(attr_t a, int j);
    return a.lsbf ? j : int'(a.fsz) - j;
  endfunction

  function automatic logic [DW-1:0] fmask(attr_t a);
    return DW'((64'd1 << (int'(a.fsz) + 1)) - 1);
  endfunction

  // bench model of the stored sets and expected counter
  attr_t m_attr [N_SETS];
  int    exp_cnt = 0;
  int    n_push = 0, frames_done = 0;

  // slave model state
  attr_t         f_attr;
  logic [DW-1:0] f_data, f_pat, mcap;
  logic          f_clr;
  logic          prev_sclk = 1'b0, prev_cs = 1'b1, smp, was_ready = 1'b0;
  int cyc = 0, lead, trail, nsmp, nedges, hp_bad;
  int cs_fall_c, first_edge_c, last_edge_c, rise_c = -1, prev_dt = 0, last_nedges = 0, j;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (tx_pop) begin
        f_attr = m_attr[q_sel[qh % 64]];
        f_data = q_data[qh % 64];
        f_pat  = q_pat[qh % 64];
        f_clr  = q_clr[qh % 64];
        qh++;
      end
      if (prev_cs && !cs_n) begin
        cs_fall_c = cyc; lead = 0; trail = 0; nsmp = 0; nedges = 0; mcap = '0; hp_bad = 0;
        if (rise_c >= 0 && was_ready)
          chk(cyc - rise_c == prev_dt + 2, "R8", "gap between frames", cyc - rise_c, prev_dt + 2);
      end else if (!cs_n && sclk != prev_sclk) begin
        nedges++;
        if (nedges == 1) first_edge_c = cyc;
        else if (cyc - last_edge_c != int'(f_attr.baud) + 1) hp_bad++;
        last_edge_c = cyc;
        if (prev_sclk == f_attr.cpol) begin lead++;  smp = !f_attr.cpha; end
        else                          begin trail++; smp = f_attr.cpha;  end
        if (smp && nsmp <= int'(f_attr.fsz)) begin
          mcap[pos(f_attr, nsmp)] = mosi;
          nsmp++;
        end
      end
      if (!prev_cs && cs_n) begin
        frames_done++;
        last_nedges = nedges;
        chk(nedges == 2 * (int'(f_attr.fsz) + 1), "R3/R4", "sclk transitions", nedges, 2 * (int'(f_attr.fsz) + 1));
        chk(mcap == (f_data & fmask(f_attr)), "R5", "mosi word", mcap, f_data & fmask(f_attr));
        chk(rx_push && rx_data == (f_pat & fmask(f_attr)), "R9", "rx word", rx_data, f_pat & fmask(f_attr));
        chk(hp_bad == 0, "R7", "half-period misses", hp_bad, 0);
        chk(first_edge_c - cs_fall_c == int'(f_attr.cssck) + int'(f_attr.baud) + 2, "R8", "cs to first edge",
            first_edge_c - cs_fall_c, int'(f_attr.cssck) + int'(f_attr.baud) + 2);
        chk(cyc - last_edge_c == int'(f_attr.asc) + 1, "R8", "last edge to cs", cyc - last_edge_c, int'(f_attr.asc) + 1);
        chk(sclk == f_attr.cpol, "R6", "idle clock level", sclk, f_attr.cpol);
        exp_cnt = ((f_clr ? 0 : exp_cnt) + 1) & 16'hFFFF;
        chk(xfer_cnt == CNT_W'(exp_cnt), "R10", "frame counter", xfer_cnt, exp_cnt);
        rise_c = cyc; prev_dt = int'(f_attr.dt); was_ready = !tx_empty && !rx_full;
      end
      if (!cs_n) begin
        j = f_attr.cpha ? ((lead > 0) ? lead - 1 : 0) : trail;
        miso = (j <= int'(f_attr.fsz)) ? f_pat[pos(f_attr, j)] : 1'b0;
      end
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
  end

  task automatic push(logic [SEL_W-1:0] s, logic c, logic [DW-1:0] d, logic [DW-1:0] p);
    q_sel[qt % 64] = s; q_clr[qt % 64] = c; q_data[qt % 64] = d; q_pat[qt % 64] = p;
    qt++; n_push++;
  endtask

  task automatic wr(int addr, logic [ATTR_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = REG_AW'(addr); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_attr(int s, attr_t a);
    wr(s, a);
    m_attr[s] = a;
  endtask

  task automatic wait_idle();
    while (frames_done != n_push) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  function automatic attr_t mk(int fsz, bit pol, bit pha, bit lsb, int baud, int css, int asc, int dt);
    attr_t a;
    a.fsz = FSZ_W'(fsz); a.cpol = pol; a.cpha = pha; a.lsbf = lsb;
    a.baud = BAUD_W'(baud); a.cssck = DLY_W'(css); a.asc = DLY_W'(asc); a.dt = DLY_W'(dt);
    return a;
  endfunction

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < N_SETS; i++) m_attr[i] = ATTR_RST;
    for (int i = 0; i < 64; i++) begin
      q_sel[i] = '0; q_clr[i] = 1'b0; q_data[i] = '0; q_pat[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1", "pins after reset", {cs_n, sclk, mosi}, 3'b100);
    chk(xfer_cnt == '0 && !tx_pop && !rx_push, "R1", "counter and strobes", xfer_cnt, 0);

    // R1 R4 default 16-bit frame with reset attributes
    push(0, 0, 16'hA5C3, 16'h3C5A);
    wait_idle();
    chk(last_nedges == 32, "R1", "default frame length", last_nedges, 32);

    // R3 R6 two distinct sets used alternately, back to back
    set_attr(0, mk(7, 1, 0, 0, 1, 2, 1, 3));
    set_attr(1, mk(4, 0, 1, 1, 2, 0, 0, 0));
    push(0, 0, 16'h00B7, 16'h005C);
    push(1, 0, 16'h0013, 16'h000A);
    push(0, 0, 16'h0042, 16'h00E1);
    push(1, 0, 16'h001F, 16'h0015);
    wait_idle();

    // R2 receive queue full blocks start
    rx_full = 1'b1;
    push(1, 0, 16'h0009, 16'h0016);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 5 == 4) chk(cs_n && !tx_pop && qh != qt, "R2", "no start while rx_full", {cs_n, tx_pop}, 2'b10);
    end
    rx_full = 1'b0;
    wait_idle();
    chk(qh == qt, "R2", "entry popped once space freed", qt - qh, 0);

    // R12 preset, R10 wrap
    wr(N_SETS, ATTR_W'(16'h1234));
    chk(xfer_cnt == 16'h1234, "R12", "counter preset", xfer_cnt, 16'h1234);
    exp_cnt = 16'h1234;
    wr(N_SETS, ATTR_W'(16'hFFFF));
    exp_cnt = 16'hFFFF;
    push(1, 0, 16'h0011, 16'h0002);
    wait_idle();
    chk(xfer_cnt == '0, "R10", "wrap to zero", xfer_cnt, 0);

    // R11 clear at frame start
    wr(N_SETS, ATTR_W'(16'h0050));
    exp_cnt = 16'h0050;
    push(0, 1, 16'h00C6, 16'h0033);
    while (cs_n) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(xfer_cnt == '0, "R11", "cleared at frame start", xfer_cnt, 0);
    wait_idle();
    chk(xfer_cnt == 16'd1, "R11", "count after cleared frame", xfer_cnt, 1);

    // R13 write to set 0 during a frame is dropped
    push(0, 0, 16'h005A, 16'h00A5);
    while (cs_n) @(negedge clk);
    wr(0, mk(2, 0, 1, 1, 0, 0, 0, 0));
    wait_idle();
    push(0, 0, 16'h0077, 16'h0088);
    wait_idle();
    chk(last_nedges == 16, "R13", "set 0 length kept", last_nedges, 16);

    // random batches
    for (int b = 0; b < 6; b++) begin
      for (int s = 0; s < N_SETS; s++)
        set_attr(s, mk($urandom % 16, $urandom % 2, $urandom % 2, $urandom % 2,
                       $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4));
      for (int f = 0; f < 4; f++)
        push(SEL_W'($urandom % 2), ($urandom % 8) == 0, DW'($urandom), DW'($urandom));
      wait_idle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "WATCHDOG", "run did not complete", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule